// File: doc/BRIEF.md
# Video Memory Access Port

This block is the processor-side window into the video memory. The processor places a 16-bit word address in a pointer register, one byte at a time. It writes the low or the high byte of the addressed word through two separate data registers, and it reads bytes back through a one-word prefetch buffer. A control register sets three things: the step added to the pointer after an access, which byte lane triggers that step, and one of four bit-rotation remaps. The remap is applied to the pointer each time an access is made. It lets software walk tile data in column order without recomputing addresses.

The block also takes the beam position from the video timing generator. While the display is running, it drops or alters writes that arrive during the visible lines and a few edge dots, and reads during the visible area return zero. A forced-blank input removes all of these restrictions. The memory is an internal single-cycle synchronous RAM with byte enables. Its depth is a parameter, and the remapped word address is truncated to that depth.

Top module: `vram_port`

## Requirements
- R1: Control bits [1:0] set the pointer step: 0 adds 1, 1 adds 32, 2 and 3 add 128. The pointer wraps modulo 65536.
- R2: Control bit 7 picks the trigger lane: 0 steps after low-byte accesses, 1 after high-byte accesses. An access on the other lane leaves the pointer unchanged.
- R3: Control bits [3:2] pick the remap. In mode 0 the word address is the pointer. For mode k (1..3), with F = 7+k, bits 15:F are kept, pointer bits F-4:0 move up by three, and pointer bits F-1:F-3 become bits 2:0.
- R4: Writing the pointer's low byte (reg_sel 1) or high byte (reg_sel 2) refills the prefetch buffer from the new remapped address.
- R5: Reads with reg_sel 3 (low) or 4 (high) return that byte of the buffer on rd_data after the clock edge. A read on the trigger lane then refills the buffer from the remapped pointer before stepping. rd_data holds its value when no data read occurs.
- R6: When not force-blanked, data writes on lines 1 through 224 (239 when overscan is set) are dropped.
- R7: When not force-blanked: on line 0, writes at dot 4 or earlier land, a write at dot 6 stores bus_prev instead of the data, and writes at other dots are dropped. On the line after the last visible line, writes at dot 4 or earlier are dropped.
- R8: When not force-blanked, buffer fills on lines below the last visible line yield zero. On the last visible line, a fill yields real data only at dot 1362.
- R9: With force_blank high, every access reaches memory regardless of the beam position.
- R10: After reset the control register, the pointer, the buffer and rd_data are zero. The register selects are: 0 control, 1 pointer low, 2 pointer high, 3 data low, 4 data high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored when wr_en is high) |
| reg_sel | input | 3 | Register select |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Last byte read from the data registers |
| force_blank | input | 1 | Display forced off; lifts access blocking |
| overscan | input | 1 | Extends the visible area to 239 lines |
| beam_line | input | 9 | Current beam line |
| beam_dot | input | 11 | Current beam dot |
| bus_prev | input | 8 | Open-bus byte stored by the dot-6 write on line 0 |

## Verification
A wrong pointer, remap or trigger state does not show at once. It shows on the next data read as a byte from the wrong word: within one access when the fault is in the buffer refill, or after one step when the fault is in the increment. The bench fills the memory with a per-word pattern so that every misdirected access returns a distinct, recognisable value. It then sweeps every combination of remap, step and trigger, with pointers close enough to the top to wrap. A second sweep walks the beam edge lines and dots with and without overscan and forced blank. Each sweep reads back both the prefetched byte and the stored byte.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
  localparam int WORD_W = 16;
  localparam int LINE_W = 9;
  localparam int DOT_W  = 11;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic       inc_on_hi;
    logic [2:0] unused;
    logic [1:0] remap;
    logic [1:0] step;
  } port_ctrl_t;
endpackage

// File: rtl/vram_remap.sv
module vram_remap
  import vram_port_pkg::*;
(
  input  logic [WORD_W-1:0] addr_in,
  input  logic [1:0]        mode,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] variant [4];

  assign variant[0] = addr_in;

  for (genvar m = 1; m < 4; m++) begin : g_rot
    localparam int F = 7 + m;
    assign variant[m] = {addr_in[WORD_W-1:F], addr_in[F-4:0], addr_in[F-1:F-3]};
  end

  assign word_out = variant[mode];
endmodule

// File: rtl/vram_beam_gate.sv
module vram_beam_gate
  import vram_port_pkg::*;
#(
  parameter int VIS_STD   = 224,
  parameter int VIS_OVR   = 239,
  parameter int EARLY_DOT = 4,
  parameter int BUS_DOT   = 6,
  parameter int READ_DOT  = 1362
) (
  input  logic              force_blank,
  input  logic              overscan,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  output logic              wr_ok,
  output logic              wr_use_bus,
  output logic              rd_ok
);
  localparam logic [LINE_W-1:0] LAST_S = LINE_W'(VIS_STD);
  localparam logic [LINE_W-1:0] LAST_O = LINE_W'(VIS_OVR);
  localparam logic [DOT_W-1:0]  D_EARLY = DOT_W'(EARLY_DOT);
  localparam logic [DOT_W-1:0]  D_BUS   = DOT_W'(BUS_DOT);
  localparam logic [DOT_W-1:0]  D_READ  = DOT_W'(READ_DOT);

  logic [LINE_W-1:0] last_vis;
  logic [LINE_W-1:0] first_after;

  assign last_vis    = overscan ? LAST_O : LAST_S;
  assign first_after = last_vis + 1'b1;

  always_comb begin
    wr_ok      = 1'b1;
    wr_use_bus = 1'b0;
    rd_ok      = 1'b1;
    if (!force_blank) begin
      if (line == '0) begin
        wr_ok      = (dot <= D_EARLY) || (dot == D_BUS);
        wr_use_bus = (dot == D_BUS);
      end else if (line <= last_vis) begin
        wr_ok = 1'b0;
      end else if (line == first_after) begin
        wr_ok = (dot > D_EARLY);
      end
      if (line < last_vis) begin
        rd_ok = 1'b0;
      end else if (line == last_vis) begin
        rd_ok = (dot == D_READ);
      end
    end
  end
endmodule

// File: rtl/vram_store.sv
module vram_store #(
  parameter int AW    = 10,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic               re,
  input  logic [AW-1:0]      addr,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [8*LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (be[l]) mem[addr][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int MEM_AW  = 10,
  parameter int VIS_STD = 224,
  parameter int VIS_OVR = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              force_blank,
  input  logic              overscan,
  input  logic [LINE_W-1:0] beam_line,
  input  logic [DOT_W-1:0]  beam_dot,
  input  logic [7:0]        bus_prev
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // state
  port_ctrl_t        ctrl_q, ctrl_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] pf_q;
  logic              pend_q, pend_blk_q;
  logic [7:0]        rd_data_q, rd_data_d;
  logic              ctrl_en, addr_en;

  // decode
  reg_sel_e          sel;
  logic              addr_wr, data_wr, data_rd, hi_lane, trig, reload;
  logic [WORD_W-1:0] addr_new, remap_in, word_addr, step_val, pf_eff;
  logic [WORD_W-1:0] ram_q;
  logic              wr_ok, wr_use_bus, rd_ok;
  logic              ram_we;
  logic [7:0]        wr_byte;

  assign sel      = reg_sel_e'(reg_sel);
  assign hi_lane  = (sel == SEL_DATA_HI);
  assign addr_wr  = wr_en && ((sel == SEL_ADDR_LO) || (sel == SEL_ADDR_HI));
  assign data_wr  = wr_en && ((sel == SEL_DATA_LO) || (sel == SEL_DATA_HI));
  assign data_rd  = rd_en && !wr_en && ((sel == SEL_DATA_LO) || (sel == SEL_DATA_HI));
  assign trig     = (data_wr || data_rd) && (hi_lane == ctrl_q.inc_on_hi);
  assign reload   = addr_wr || (data_rd && trig);
  assign addr_new = (sel == SEL_ADDR_LO) ? {addr_q[15:8], wr_data} : {wr_data, addr_q[7:0]};
  assign remap_in = addr_wr ? addr_new : addr_q;

  always_comb begin
    case (ctrl_q.step)
      2'd0:    step_val = 16'd1;
      2'd1:    step_val = 16'd32;
      default: step_val = 16'd128;
    endcase
  end

  vram_remap u_remap (
    .addr_in  (remap_in),
    .mode     (ctrl_q.remap),
    .word_out (word_addr)
  );

  vram_beam_gate #(
    .VIS_STD (VIS_STD),
    .VIS_OVR (VIS_OVR)
  ) u_gate (
    .force_blank (force_blank),
    .overscan    (overscan),
    .line        (beam_line),
    .dot         (beam_dot),
    .wr_ok       (wr_ok),
    .wr_use_bus  (wr_use_bus),
    .rd_ok       (rd_ok)
  );

  assign ram_we  = data_wr && wr_ok;
  assign wr_byte = wr_use_bus ? bus_prev : wr_data;

  vram_store #(
    .AW    (MEM_AW),
    .LANES (2)
  ) u_store (
    .clk   (clk),
    .we    (ram_we),
    .be    ({hi_lane, !hi_lane}),
    .re    (reload),
    .addr  (word_addr[MEM_AW-1:0]),
    .wdata ({wr_byte, wr_byte}),
    .rdata (ram_q)
  );

  // buffer as seen this cycle: a fill issued last cycle bypasses the register
  assign pf_eff = pend_q ? (pend_blk_q ? '0 : ram_q) : pf_q;

  // next state
  always_comb begin
    ctrl_en   = wr_en && (sel == SEL_CTRL);
    ctrl_d    = port_ctrl_t'(wr_data);
    addr_en   = addr_wr || trig;
    addr_d    = addr_wr ? addr_new : addr_q + step_val;
    rd_data_d = hi_lane ? pf_eff[15:8] : pf_eff[7:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q     <= '0;
      addr_q     <= '0;
      pf_q       <= '0;
      pend_q     <= 1'b0;
      pend_blk_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q    <= ctrl_d;
      if (addr_en) addr_q    <= addr_d;
      if (pend_q)  pf_q      <= pf_eff;
      if (data_rd) rd_data_q <= rd_data_d;
      pend_q     <= reload;
      pend_blk_q <= reload && !rd_ok;
    end
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk
  import vram_port_pkg::*;
#(
  parameter int VIS_STD = 224,
  parameter int VIS_OVR = 239
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        reg_sel,
  input logic              force_blank,
  input logic              overscan,
  input logic [LINE_W-1:0] beam_line,
  input logic [7:0]        rd_data,
  input port_ctrl_t        ctrl_q,
  input logic [WORD_W-1:0] addr_q,
  input logic [WORD_W-1:0] pf_q,
  input logic              ram_we
);
  logic [LINE_W-1:0] last_vis;
  logic              data_sel, acc, on_trig;

  assign last_vis = overscan ? LINE_W'(VIS_OVR) : LINE_W'(VIS_STD);
  assign data_sel = (reg_sel == 3'd3) || (reg_sel == 3'd4);
  assign acc      = data_sel && (wr_en || rd_en);
  assign on_trig  = acc && ((reg_sel == 3'd4) == ctrl_q.inc_on_hi);

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (on_trig && ctrl_q.step == 2'd0) |=> (addr_q == $past(addr_q) + 16'd1)); // R1

  AST_OTHER_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc && !on_trig) |=> $stable(addr_q)); // R2

  AST_IDLE_RDDATA: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(rd_en && !wr_en && data_sel) |=> $stable(rd_data)); // R5

  AST_VISIBLE_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!force_blank && wr_en && data_sel && beam_line != '0 && beam_line <= last_vis) |-> !ram_we); // R6

  AST_VISIBLE_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!force_blank && wr_en && (reg_sel == 3'd1 || reg_sel == 3'd2) && beam_line < last_vis)
    |=> ##1 (pf_q == '0)); // R8

  AST_BLANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (force_blank && wr_en && data_sel) |-> ram_we); // R9
endmodule

bind vram_port vram_port_chk #(
  .VIS_STD (VIS_STD),
  .VIS_OVR (VIS_OVR)
) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .reg_sel     (reg_sel),
  .force_blank (force_blank),
  .overscan    (overscan),
  .beam_line   (beam_line),
  .rd_data     (rd_data),
  .ctrl_q      (ctrl_q),
  .addr_q      (addr_q),
  .pf_q        (pf_q),
  .ram_we      (ram_we)
);

// File: tb/vram_port_bench.sv
module vram_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [2:0] reg_sel;
  logic [7:0] wr_data, rd_data;
  logic       b_blank, b_ov;
  logic [8:0] b_line;
  logic [10:0] b_dot;
  logic [7:0] bus_prev;

  int n_chk = 0;
  int n_err = 0;

  // behavioural model state
  logic [15:0] mem [1024];
  logic [15:0] m_addr, m_buf;
  logic [7:0]  m_ctrl;

  always #4 clk = ~clk;

  vram_port u_vram_port (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .reg_sel (reg_sel), .wr_data (wr_data), .rd_data (rd_data),
    .force_blank (b_blank), .overscan (b_ov), .beam_line (b_line),
    .beam_dot (b_dot), .bus_prev (bus_prev)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_remap(input logic [15:0] a, input logic [1:0] md);
    case (md)
      2'd0: return a;
      2'd1: return (a & 16'hFF00) | ((a & 16'h001F) << 3) | ((a >> 5) & 16'h7);
      2'd2: return (a & 16'hFE00) | ((a & 16'h003F) << 3) | ((a >> 6) & 16'h7);
      default: return (a & 16'hFC00) | ((a & 16'h007F) << 3) | ((a >> 7) & 16'h7);
    endcase
  endfunction

  function automatic int m_idx();
    return int'(m_remap(m_addr, m_ctrl[3:2]) & 16'h03FF);
  endfunction

  function automatic int m_last();
    return b_ov ? 239 : 224;
  endfunction

  // 0 dropped, 1 data, 2 open-bus byte
  function automatic int m_wkind();
    if (b_blank) return 1;
    if (b_line == 0) return (b_dot <= 4) ? 1 : ((b_dot == 6) ? 2 : 0);
    if (b_line <= m_last()) return 0;
    if (b_line == m_last() + 1) return (b_dot <= 4) ? 0 : 1;
    return 1;
  endfunction

  function automatic bit m_rdok();
    if (b_blank) return 1;
    if (b_line < m_last()) return 0;
    if (b_line == m_last()) return b_dot == 1362;
    return 1;
  endfunction

  function automatic logic [15:0] m_step();
    case (m_ctrl[1:0])
      2'd0: return 16'd1;
      2'd1: return 16'd32;
      default: return 16'd128;
    endcase
  endfunction

  task automatic m_fill();
    m_buf = m_rdok() ? mem[m_idx()] : 16'h0;
  endtask

  task automatic put(input logic [2:0] s, input logic [7:0] d);
    int k;
    wr_en = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      3'd0: m_ctrl = d;
      3'd1: begin m_addr[7:0] = d; m_fill(); end
      3'd2: begin m_addr[15:8] = d; m_fill(); end
      default: begin
        k = m_wkind();
        if (k != 0) begin
          if (s == 3'd4) mem[m_idx()][15:8] = (k == 2) ? bus_prev : d;
          else           mem[m_idx()][7:0]  = (k == 2) ? bus_prev : d;
        end
        if ((s == 3'd4) == m_ctrl[7]) m_addr = m_addr + m_step();
      end
    endcase
  endtask

  task automatic get(input logic [2:0] s, input string tag);
    logic [7:0] exp;
    rd_en = 1'b1; reg_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    exp = (s == 3'd4) ? m_buf[15:8] : m_buf[7:0];
    if ((s == 3'd4) == m_ctrl[7]) begin
      m_fill();
      m_addr = m_addr + m_step();
    end
    chk(tag, rd_data, exp);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    put(3'd1, a[7:0]);
    put(3'd2, a[15:8]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    wr_en = 0; rd_en = 0; reg_sel = 0; wr_data = 0;
    b_blank = 1; b_ov = 0; b_line = 0; b_dot = 0; bus_prev = 8'hA5;
    m_addr = 0; m_buf = 0; m_ctrl = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: reset state at the port, and the cleared buffer
    chk("R10 rd_data after reset", rd_data, 8'h00);
    rd_en = 1; reg_sel = 3'd3;
    @(negedge clk);
    rd_en = 0;
    chk("R10 buffer after reset", rd_data, 8'h00);

    // fill memory under forced blank, step 1 on the high lane
    put(3'd0, 8'h80);
    set_ptr(16'h0000);
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] v;
      v = 16'(i * 40503) ^ 16'h1234;
      put(3'd3, v[7:0]);
      put(3'd4, v[15:8]);
    end

    // R1 R2 R3 R4 R5: every remap, step and trigger lane
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 2; t++) begin
          logic [15:0] base;
          base = (t != 0 ? 16'hFF80 : 16'h1200) + 16'(m * 291) + 16'(s * 5);
          put(3'(0), 8'(t * 128 + m * 4 + s));
          set_ptr(base);
          for (int r = 0; r < 3; r++) begin
            get(3'd3, "R1 R3 R4 R5 low read");
            get(3'd4, "R2 R3 R5 high read");
          end
          put(3'd3, 8'(m * 16 + s * 2 + t));
          put(3'd4, 8'(8'hE0 ^ (m * 16 + s)));
          set_ptr(base);
          get(3'd3, "R1 R3 low read-back");
          get(3'd4, "R2 R3 high read-back");
        end
      end
    end

    // R6 R7 R8 R9: beam edge lines and dots
    put(3'd0, 8'h80);
    for (int bl = 0; bl < 2; bl++) begin
      for (int ov = 0; ov < 2; ov++) begin
        for (int li = 0; li < 7; li++) begin
          for (int di = 0; di < 7; di++) begin
            int lines [7];
            int dots [7];
            int last;
            logic [15:0] a;
            string tag;
            last = (ov != 0) ? 239 : 224;
            lines = '{0, 1, last - 1, last, last + 1, last + 2, 300};
            dots  = '{0, 4, 5, 6, 7, 200, 1362};
            a = 16'(64 + (bl * 98 + ov * 49 + li * 7 + di));
            if (bl != 0)                      tag = "R9 forced blank";
            else if (li == 0 || li == 4)      tag = "R7 edge line";
            else if (li == 3)                 tag = "R8 last visible line";
            else                              tag = "R6 R8 beam window";
            b_blank = bl[0]; b_ov = ov[0];
            b_line = 9'(lines[li]); b_dot = 11'(dots[di]);
            set_ptr(a);
            get(3'd3, {tag, " fill"});
            put(3'd3, 8'(8'hC3 ^ (li * 7 + di)));
            b_blank = 1'b1;
            set_ptr(a);
            get(3'd3, {tag, " stored"});
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule